// File: doc/BRIEF.md
# Flow action resolver

The block turns the outcome of a rule-match lookup into a forwarding decision. A table of 64-bit action words, one per rule slot, is loaded through a host write port. The index of a slot is the same location number the match table reports on a hit, so a rule and its action share one address.

On each lookup the block reads the addressed word and decodes it. A decoded word can:

- drop the packet, or steer it to a queue named in the word;
- bump one of a bank of saturating hit counters;
- ask for a second lookup stage with a chosen key;
- stamp a rule identifier into the packet descriptor.

A lookup that missed produces a plain accept to a configurable default queue. Results appear one clock after the lookup strobe.

Top module: `flow_action_resolver`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `res_vld_o` is 0 and every result output is 0. All hit counters start at 0, so the first counted hit on any counter reports a value of 1.
- R2: Loading and result timing.
  - When `wr_en_i` is high at a rising edge, `wr_data_i` is stored as the action word of slot `wr_idx_i`.
  - A lookup with `lk_vld_i` high at edge N raises `res_vld_o` for exactly the cycle after edge N.
  - During that cycle `res_hit_o` equals the `lk_hit_i` that was sampled at edge N.
- R3: On a miss (`res_vld_o`=1, `res_hit_o`=0) the outputs are as follows, and no counter changes:

  | Output | Value |
  |---|---|
  | `drop_o` | 0 |
  | `qid_o` | `DEF_QID` |
  | `cnt_en_o`, `cnt_sel_o`, `cnt_val_o` | 0 |
  | `next_en_o`, `next_key_o` | 0 |
  | `tag_en_o`, `rule_id_o` | 0 |

- R4: On a hit whose word has bit 0 set, the packet is dropped:
  - `drop_o`=1;
  - `qid_o`=0;
  - `next_en_o`=0 and `next_key_o`=0.

  This holds even when bit 1 is also set; drop has priority.
- R5: On a hit with bit 0 clear, the queue choice depends on bit 1.
  - If bit 1 is set, `qid_o` is word bits [2 +: QID_W] (bits 11:2 at the default width).
  - If bit 1 is clear, `qid_o` is `DEF_QID`.
  - In both cases `drop_o`=0.
- R6: Counter selection and update.
  - On a hit whose word has bit 12 set, `cnt_en_o`=1 and `cnt_sel_o` is word bits 20:13.
  - The counter used is `cnt_sel_o` modulo `NUM_CNTS`.
  - `cnt_val_o` shows that counter's value after this hit's increment.
  - Each such hit increments the counter once.
  - When bit 12 is clear, `cnt_en_o`, `cnt_sel_o` and `cnt_val_o` are 0.
- R7: A counter that holds 2^CNT_W-1 stays at that value on further hits, and `cnt_val_o` then reports 2^CNT_W-1.
- R8: On a hit with word bit 21 set and bit 0 clear, `next_en_o`=1 and `next_key_o` is word bits 27:22. Otherwise both are 0.
- R9: On a hit with word bit 32 set, `tag_en_o`=1 and `rule_id_o` is word bits 45:33. Otherwise both are 0.
- R10: In a cycle with `res_vld_o`=0 every result output is 0, including after a cycle that performed only a table write.
- R11: If a write and a lookup target the same slot at the same edge, the lookup decodes the word held before the write. The next lookup decodes the new word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en_i | input | 1 | Action table write strobe |
| wr_idx_i | input | IDX_W | Slot written |
| wr_data_i | input | 64 | Action word written |
| lk_vld_i | input | 1 | Lookup strobe |
| lk_hit_i | input | 1 | Match table reported a hit |
| lk_idx_i | input | IDX_W | Slot of the matching rule |
| res_vld_o | output | 1 | Result valid |
| res_hit_o | output | 1 | Result comes from a hit |
| drop_o | output | 1 | Drop the packet |
| qid_o | output | QID_W | Destination queue |
| cnt_en_o | output | 1 | A counter was bumped |
| cnt_sel_o | output | 8 | Counter select field |
| cnt_val_o | output | CNT_W | Counter value after the bump |
| next_en_o | output | 1 | Request a next-stage lookup |
| next_key_o | output | 6 | Next-stage key selector |
| tag_en_o | output | 1 | Write the rule ID into the descriptor |
| rule_id_o | output | 13 | Rule ID to write |

## Verification
The bound checker covers the relations that hold on every cycle:

- the one-cycle alignment of `res_vld_o` with the lookup strobe;
- the fixed default outputs on a miss;
- drop forcing queue 0 and no next stage;
- quiet outputs when no result is valid;
- a reported counter value that never wraps to zero.

Only the bench's scenarios show the rest:

- that decoded fields come from the right bit positions of the right slot;
- that two select values sharing a counter modulo the bank size accumulate together;
- the exact point where the counter saturates;
- read-before-write ordering on a same-slot collision.

// File: rtl/fa_pkg.sv
package fa_pkg;
  localparam int WORD_W    = 64;
  // lower word
  localparam int DROP_B    = 0;
  localparam int DQ_B      = 1;
  localparam int QID_LSB   = 2;
  localparam int QID_FLD_W = 10;
  localparam int UCNT_B    = 12;
  localparam int CNT_LSB   = 13;
  localparam int CNT_FLD_W = 8;
  localparam int NXT_B     = 21;
  localparam int NKEY_LSB  = 22;
  localparam int NKEY_W    = 6;
  // upper word
  localparam int TAG_B     = 32;
  localparam int RID_LSB   = 33;
  localparam int RID_W     = 13;
endpackage

// File: rtl/fa_action_ram.sv
module fa_action_ram #(
  parameter int DEPTH = 64,
  parameter int W     = 64,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          we_i,
  input  logic [AW-1:0] wa_i,
  input  logic [W-1:0]  wd_i,
  input  logic          re_i,
  input  logic [AW-1:0] ra_i,
  output logic [W-1:0]  rd_o
);
  logic [W-1:0] mem [DEPTH];

  // Nonblocking write and read in one process give read-before-write.
  always_ff @(posedge clk) begin
    if (we_i) mem[wa_i] <= wd_i;
    if (re_i) rd_o <= mem[ra_i];
  end
endmodule

// File: rtl/fa_decode.sv
module fa_decode import fa_pkg::*; #(
  parameter int QID_W = 10,
  parameter logic [QID_W-1:0] DEF_QID = '0
) (
  input  logic [WORD_W-1:0]    word_i,
  input  logic                 vld_i,
  input  logic                 hit_i,
  output logic                 drop_o,
  output logic [QID_W-1:0]     qid_o,
  output logic                 cnt_en_o,
  output logic [CNT_FLD_W-1:0] cnt_sel_o,
  output logic                 next_en_o,
  output logic [NKEY_W-1:0]    next_key_o,
  output logic                 tag_en_o,
  output logic [RID_W-1:0]     rule_id_o
);
  logic use_hit;
  logic unused_bits;

  assign use_hit     = vld_i & hit_i;
  assign unused_bits = ^{word_i[WORD_W-1:RID_LSB+RID_W], word_i[TAG_B-1:NKEY_LSB+NKEY_W]};

  always_comb begin
    drop_o     = 1'b0;
    qid_o      = '0;
    cnt_en_o   = 1'b0;
    cnt_sel_o  = '0;
    next_en_o  = 1'b0;
    next_key_o = '0;
    tag_en_o   = 1'b0;
    rule_id_o  = '0;
    if (vld_i) begin
      qid_o = DEF_QID;
      if (use_hit) begin
        if (word_i[DROP_B]) begin
          drop_o = 1'b1;
          qid_o  = '0;
        end else if (word_i[DQ_B]) begin
          qid_o = word_i[QID_LSB +: QID_W];
        end
        if (word_i[UCNT_B]) begin
          cnt_en_o  = 1'b1;
          cnt_sel_o = word_i[CNT_LSB +: CNT_FLD_W];
        end
        if (word_i[NXT_B] && !word_i[DROP_B]) begin
          next_en_o  = 1'b1;
          next_key_o = word_i[NKEY_LSB +: NKEY_W];
        end
        if (word_i[TAG_B]) begin
          tag_en_o  = 1'b1;
          rule_id_o = word_i[RID_LSB +: RID_W];
        end
      end
    end
  end
endmodule

// File: rtl/fa_cnt_bank.sv
module fa_cnt_bank #(
  parameter int NUM_CNTS = 16,
  parameter int CNT_W    = 32,
  parameter int SEL_W    = 8,
  localparam int CSEL_W  = (NUM_CNTS > 1) ? $clog2(NUM_CNTS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic [CNT_W-1:0] val_o
);
  logic [CNT_W-1:0]  cnt_q [NUM_CNTS];
  logic [CSEL_W-1:0] idx;
  logic [CNT_W-1:0]  cur;
  logic              unused_sel;

  assign idx        = sel_i[CSEL_W-1:0];
  assign unused_sel = ^sel_i;
  assign cur        = cnt_q[idx];
  assign val_o      = (&cur) ? cur : cur + CNT_W'(1);

  for (genvar g = 0; g < NUM_CNTS; g++) begin : g_cnt
    always_ff @(posedge clk) begin
      if (rst)                                  cnt_q[g] <= '0;
      else if (inc_i && idx == CSEL_W'(g))      cnt_q[g] <= val_o;
    end
  end
endmodule

// File: rtl/flow_action_resolver.sv
module flow_action_resolver import fa_pkg::*; #(
  parameter int NUM_RULES = 64,
  parameter int QID_W     = 10,
  parameter logic [QID_W-1:0] DEF_QID = '0,
  parameter int NUM_CNTS  = 16,
  parameter int CNT_W     = 32,
  localparam int IDX_W    = (NUM_RULES > 1) ? $clog2(NUM_RULES) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en_i,
  input  logic [IDX_W-1:0]     wr_idx_i,
  input  logic [WORD_W-1:0]    wr_data_i,
  input  logic                 lk_vld_i,
  input  logic                 lk_hit_i,
  input  logic [IDX_W-1:0]     lk_idx_i,
  output logic                 res_vld_o,
  output logic                 res_hit_o,
  output logic                 drop_o,
  output logic [QID_W-1:0]     qid_o,
  output logic                 cnt_en_o,
  output logic [CNT_FLD_W-1:0] cnt_sel_o,
  output logic [CNT_W-1:0]     cnt_val_o,
  output logic                 next_en_o,
  output logic [NKEY_W-1:0]    next_key_o,
  output logic                 tag_en_o,
  output logic [RID_W-1:0]     rule_id_o
);
  logic              vld_q, hit_q;
  logic [WORD_W-1:0] act_word;
  logic [CNT_W-1:0]  bank_val;

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= 1'b0;
      hit_q <= 1'b0;
    end else begin
      vld_q <= lk_vld_i;
      hit_q <= lk_vld_i & lk_hit_i;
    end
  end

  fa_action_ram #(.DEPTH(NUM_RULES), .W(WORD_W)) u_ram (
    .clk (clk),
    .we_i(wr_en_i),
    .wa_i(wr_idx_i),
    .wd_i(wr_data_i),
    .re_i(lk_vld_i & lk_hit_i),
    .ra_i(lk_idx_i),
    .rd_o(act_word)
  );

  fa_decode #(.QID_W(QID_W), .DEF_QID(DEF_QID)) u_dec (
    .word_i    (act_word),
    .vld_i     (vld_q),
    .hit_i     (hit_q),
    .drop_o    (drop_o),
    .qid_o     (qid_o),
    .cnt_en_o  (cnt_en_o),
    .cnt_sel_o (cnt_sel_o),
    .next_en_o (next_en_o),
    .next_key_o(next_key_o),
    .tag_en_o  (tag_en_o),
    .rule_id_o (rule_id_o)
  );

  fa_cnt_bank #(.NUM_CNTS(NUM_CNTS), .CNT_W(CNT_W), .SEL_W(CNT_FLD_W)) u_cnt (
    .clk  (clk),
    .rst  (rst),
    .inc_i(cnt_en_o),
    .sel_i(cnt_sel_o),
    .val_o(bank_val)
  );

  assign res_vld_o = vld_q;
  assign res_hit_o = hit_q;
  assign cnt_val_o = cnt_en_o ? bank_val : '0;
endmodule

// File: rtl/fa_resolver_chk.sv
module fa_resolver_chk import fa_pkg::*; #(
  parameter int QID_W = 10,
  parameter logic [QID_W-1:0] DEF_QID = '0,
  parameter int CNT_W = 32
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 lk_vld_i,
  input logic                 res_vld_o,
  input logic                 res_hit_o,
  input logic                 drop_o,
  input logic [QID_W-1:0]     qid_o,
  input logic                 cnt_en_o,
  input logic [CNT_FLD_W-1:0] cnt_sel_o,
  input logic [CNT_W-1:0]     cnt_val_o,
  input logic                 next_en_o,
  input logic [NKEY_W-1:0]    next_key_o,
  input logic                 tag_en_o,
  input logic [RID_W-1:0]     rule_id_o
);
  // R2
  vld_align_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (res_vld_o == $past(lk_vld_i)));

  // R2
  hit_in_vld_chk: assert property (@(posedge clk) disable iff (rst)
    res_hit_o |-> res_vld_o);

  // R3
  miss_default_chk: assert property (@(posedge clk) disable iff (rst)
    (res_vld_o && !res_hit_o) |-> (!drop_o && qid_o == DEF_QID && !cnt_en_o
                                   && !next_en_o && !tag_en_o));

  // R4
  drop_prio_chk: assert property (@(posedge clk) disable iff (rst)
    drop_o |-> (qid_o == '0 && !next_en_o && next_key_o == '0));

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !res_vld_o |-> (!res_hit_o && !drop_o && qid_o == '0 && !cnt_en_o && cnt_sel_o == '0
                    && cnt_val_o == '0 && !next_en_o && !tag_en_o && rule_id_o == '0));

  // R7
  cnt_nowrap_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_en_o |-> (cnt_val_o != '0));
endmodule

bind flow_action_resolver fa_resolver_chk #(
  .QID_W(QID_W), .DEF_QID(DEF_QID), .CNT_W(CNT_W)
) u_fa_chk (.*);

// File: tb/test_flow_action_resolver.sv
module test_flow_action_resolver;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 4;
  localparam int NC = 4;
  localparam logic [9:0] DQ = 10'd7;

  typedef struct packed {
    logic hit; logic drop; logic [9:0] qid; logic cen; logic [7:0] sel;
    logic [CW-1:0] val; logic nen; logic [5:0] nkey; logic ten; logic [12:0] rid;
  } exp_t;

  logic clk = 0, rst = 1;
  logic wr_en_i = 0, lk_vld_i = 0, lk_hit_i = 0;
  logic [5:0] wr_idx_i = 0, lk_idx_i = 0;
  logic [63:0] wr_data_i = 0;
  logic res_vld_o, res_hit_o, drop_o, cnt_en_o, next_en_o, tag_en_o;
  logic [9:0] qid_o;
  logic [7:0] cnt_sel_o;
  logic [CW-1:0] cnt_val_o;
  logic [5:0] next_key_o;
  logic [12:0] rule_id_o;

  int checks = 0, fails = 0;
  exp_t eq[$];
  string tq[$];
  logic [63:0] words [64];
  logic [CW-1:0] cnt_m [NC];

  always #(CLK_PERIOD/2) clk = ~clk;

  flow_action_resolver #(.NUM_RULES(64), .QID_W(10), .DEF_QID(DQ), .NUM_CNTS(NC), .CNT_W(CW))
  i_flow_action_resolver (.*);

  function automatic logic [63:0] mk(logic dr, logic dq, logic [9:0] q, logic uc, logic [7:0] cs,
                                     logic nx, logic [5:0] nk, logic tg, logic [12:0] rid);
    logic [63:0] w = '0;
    w[0] = dr; w[1] = dq; w[11:2] = q; w[12] = uc; w[20:13] = cs;
    w[21] = nx; w[27:22] = nk; w[32] = tg; w[45:33] = rid;
    return w;
  endfunction

  task automatic wr(input logic [5:0] idx, input logic [63:0] d);
    wr_en_i = 1; wr_idx_i = idx; wr_data_i = d;
    words[idx] = d;
    @(negedge clk);
    wr_en_i = 0;
  endtask

  function automatic exp_t predict(logic hit, logic [5:0] idx);
    exp_t e = '0;
    logic [63:0] w = words[idx];
    e.hit = hit;
    e.qid = DQ;
    if (hit) begin
      if (w[0]) begin e.drop = 1; e.qid = 0; end
      else if (w[1]) e.qid = w[11:2];
      if (w[12]) begin
        int k = int'(w[20:13]) % NC;
        e.cen = 1; e.sel = w[20:13];
        if (cnt_m[k] != {CW{1'b1}}) cnt_m[k] = cnt_m[k] + 1'b1;
        e.val = cnt_m[k];
      end
      if (w[21] && !w[0]) begin e.nen = 1; e.nkey = w[27:22]; end
      if (w[32]) begin e.ten = 1; e.rid = w[45:33]; end
    end
    return e;
  endfunction

  task automatic look(input logic hit, input logic [5:0] idx, input string tag);
    lk_vld_i = 1; lk_hit_i = hit; lk_idx_i = idx;
    eq.push_back(predict(hit, idx));
    tq.push_back(tag);
    @(negedge clk);
    lk_vld_i = 0; lk_hit_i = 0;
  endtask

  // monitor
  always @(negedge clk) begin
    if (!rst && res_vld_o) begin
      exp_t a, e;
      string t;
      a = {res_hit_o, drop_o, qid_o, cnt_en_o, cnt_sel_o, cnt_val_o,
           next_en_o, next_key_o, tag_en_o, rule_id_o};
      checks++;
      if (eq.size() == 0) begin
        fails++;
        $display("FAIL R2 unexpected result act=%h exp=none", a);
      end else begin
        e = eq.pop_front();
        t = tq.pop_front();
        if (a !== e) begin
          fails++;
          $display("FAIL %s act=%h exp=%h", t, a, e);
        end
      end
    end
  end

  task automatic chk_idle(input string tag);
    checks++;
    if (res_vld_o !== 0 || drop_o !== 0 || qid_o !== 0 || cnt_en_o !== 0 || cnt_val_o !== 0 ||
        next_en_o !== 0 || tag_en_o !== 0 || rule_id_o !== 0 || res_hit_o !== 0) begin
      fails++;
      $display("FAIL %s act vld=%b drop=%b qid=%h cen=%b val=%h nen=%b ten=%b rid=%h exp all 0",
               tag, res_vld_o, drop_o, qid_o, cnt_en_o, cnt_val_o, next_en_o, tag_en_o, rule_id_o);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) words[i] = '0;
    for (int i = 0; i < NC; i++) cnt_m[i] = '0;
    repeat (3) @(negedge clk);
    chk_idle("R1 reset");
    rst = 0;
    @(negedge clk);
    chk_idle("R1 after reset");

    wr(6'd0,  mk(0, 1, 10'd300, 0, 8'd0, 0, 6'd0, 1, 13'h0ABC));
    chk_idle("R10 write only");
    wr(6'd1,  mk(1, 1, 10'd55,  0, 8'd0, 1, 6'd9, 0, 13'd0));
    wr(6'd2,  mk(0, 1, 10'd12,  1, 8'd1, 1, 6'h2A, 0, 13'd0));
    wr(6'd3,  mk(0, 0, 10'd99,  1, 8'd5, 0, 6'd0, 1, 13'd3));
    wr(6'd4,  mk(0, 0, 10'd200, 0, 8'd0, 0, 6'd0, 0, 13'd0));
    wr(6'd63, mk(0, 1, 10'd1023, 0, 8'd0, 1, 6'h3F, 1, 13'h1FFF));
    wr(6'd5,  mk(1, 0, 10'd0,   1, 8'd2, 0, 6'd0, 1, 13'd77));
    chk_idle("R10 write only again");

    look(1, 6'd0,  "R2 R5 R9 accept with tag");
    look(1, 6'd1,  "R4 drop priority");
    look(1, 6'd2,  "R6 R8 counter first hit");
    look(1, 6'd3,  "R6 shared counter modulo");
    look(0, 6'd2,  "R3 miss");
    look(1, 6'd4,  "R5 default queue on hit");
    look(1, 6'd63, "R5 R8 R9 top slot");
    look(1, 6'd5,  "R4 R6 drop with counter");
    @(negedge clk);
    chk_idle("R10 idle after results");

    for (int i = 0; i < 16; i++) look(1, 6'd2, "R7 saturation");
    look(1, 6'd3, "R7 shared counter stays saturated");
    look(0, 6'd5, "R3 miss keeps counters");
    look(1, 6'd5, "R6 counter two");

    // R11 collision: lookup and write slot 0 together
    lk_vld_i = 1; lk_hit_i = 1; lk_idx_i = 6'd0;
    eq.push_back(predict(1, 6'd0));
    tq.push_back("R11 old word on collision");
    wr(6'd0, mk(1, 0, 10'd0, 0, 8'd0, 0, 6'd0, 0, 13'd0));
    lk_vld_i = 0; lk_hit_i = 0;
    look(1, 6'd0, "R11 new word afterwards");

    repeat (3) @(negedge clk);
    checks++;
    if (eq.size() != 0) begin
      fails++;
      $display("FAIL R2 missing results act=%0d exp=0", eq.size());
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule